// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column addresses of one SDRAM read or write burst in the order the memory expects them. A controller presents a starting column, an encoded burst length of 2, 4 or 8, and a burst type: sequential or interleaved. It then pulses a start strobe. Beginning on the next cycle, the block emits one column address per clock, with a valid flag and a flag that marks the final beat.

Only the low column bits that pick a beat inside the burst are reordered. That is one bit for a length of 2, two bits for 4 and three bits for 8. Every bit above that window is copied from the starting column and stays unchanged for the whole burst. In sequential order the beat offset counts up from the starting offset and wraps inside the window. In interleaved order, beat i carries the starting offset XOR i. Length and type are sampled when the strobe is taken. A new burst may follow the final beat with no idle cycle.

Top module: `burst_col_sequencer`

## Requirements
- R1: After reset, and until a start is accepted, `colValid`, `colLast` and `errFlag` are low.
- R2: Length code `3'b001` gives 2 beats, `3'b010` gives 4 beats and `3'b011` gives 8 beats. The beats appear on consecutive cycles, and the first one is visible in the cycle after the edge that accepts the start.
- R3: With `interleave` = 0 (sequential), beat i carries offset (s + i) mod L in the low window. Here s is the starting offset and L is the burst length; for example, L=8 with s=5 gives 5,6,7,0,1,2,3,4.
- R4: With `interleave` = 1, beat i carries offset s XOR i in the low window; for example, L=8 with s=5 gives 5,4,7,6,1,0,3,2.
- R5: Column bits above the window keep the value they had in `startCol` on every beat. For L=2 this means bits 1 and up, for L=4 bits 2 and up, and for L=8 bits 3 and up.
- R6: Changes to `lenCode`, `interleave` or `startCol` during a burst do not alter that burst.
- R7: `colLast` is high on the final beat of a burst and on no other cycle.
- R8: A start strobe that is high in the cycle of the final beat is accepted. That new burst's first beat follows in the next cycle, with no idle gap.
- R9: A start strobe during a beat that is not the final one is ignored.
- R10: A start with any other length code (`000`, `1xx`) produces no beats. It raises `errFlag` for exactly one cycle, in the cycle after the accepting edge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe for a new burst |
| startCol | input | COL_W | Starting column address |
| lenCode | input | 3 | Encoded burst length (001=2, 010=4, 011=8) |
| interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A beat is being emitted this cycle |
| colLast | output | 1 | The current beat is the final one |
| errFlag | output | 1 | One-cycle pulse for an illegal length code |

## Verification
The bound checker enforces several properties on every cycle:
- `colLast` never appears without `colValid`.
- A burst never stops before its final beat.
- The bits above the widest window stay constant inside a burst.
- An error pulse never coincides with a beat.
- Every burst ends after exactly 2, 4 or 8 beats.

Other behaviour is shown only by the bench's scenarios. This covers the exact offset order for each mode and starting point, and the pass-through of the window-dependent upper bits for short bursts. It also covers the rejection of mid-burst input changes and strobes, and the seamless hand-over on the final beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int OFF_W = 3;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;

  function automatic logic codeLegal(input logic [CODE_W-1:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic [OFF_W-1:0] codeMask(input logic [CODE_W-1:0] code);
    logic [OFF_W-1:0] m;
    case (code)
      3'b001:  m = 3'b001;
      3'b010:  m = 3'b011;
      3'b011:  m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           strobes,
  input  logic [COL_W-1:0]      startCol,
  input  logic [CODE_W-1:0]     lenCode,
  input  logic                  interleave,
  output logic [COL_W-1:0]      colOut,
  output logic                  isFinal
);

  localparam int HI_W = COL_W - OFF_W;

  logic [HI_W-1:0]  baseHi;
  logic [OFF_W-1:0] baseLo;
  logic [OFF_W-1:0] beatIdx;
  logic [OFF_W-1:0] winMask;
  logic             modeIntlv;
  logic [OFF_W-1:0] rawOff;
  logic [OFF_W-1:0] beatOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi    <= '0;
      baseLo    <= '0;
      beatIdx   <= '0;
      winMask   <= '0;
      modeIntlv <= 1'b0;
    end else if (strobes.load) begin
      baseHi    <= startCol[COL_W-1:OFF_W];
      baseLo    <= startCol[OFF_W-1:0];
      beatIdx   <= '0;
      winMask   <= codeMask(lenCode);
      modeIntlv <= interleave;
    end else if (strobes.step) begin
      beatIdx   <= beatIdx + 1'b1;
    end
  end

  always_comb begin
    if (modeIntlv) rawOff = baseLo ^ beatIdx;
    else           rawOff = baseLo + beatIdx;
    beatOff = (baseLo & ~winMask) | (rawOff & winMask);
  end

  assign colOut  = {baseHi, beatOff};
  assign isFinal = (beatIdx == winMask);

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [CODE_W-1:0] lenCode,
  input  logic              isFinal,
  output seqStrobes_t       strobes,
  output logic              busy,
  output logic              errFlag
);

  logic accept;
  logic legal;

  assign accept = startIn && (!busy || isFinal);
  assign legal  = codeLegal(lenCode);

  always_comb begin
    strobes.load = accept && legal;
    strobes.step = busy && !isFinal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      busy    <= strobes.load || (busy && !isFinal);
      errFlag <= accept && !legal;
    end
  end

endmodule

// File: rtl/burst_col_sequencer.sv
module burst_col_sequencer
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast,
  output logic             errFlag
);

  seqStrobes_t strobes;
  logic        isFinal;
  logic        busy;

  burst_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .lenCode (lenCode),
    .isFinal (isFinal),
    .strobes (strobes),
    .busy    (busy),
    .errFlag (errFlag)
  );

  burst_seq_datapath #(.COL_W(COL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .startCol   (startCol),
    .lenCode    (lenCode),
    .interleave (interleave),
    .colOut     (colOut),
    .isFinal    (isFinal)
  );

  assign colValid = busy;
  assign colLast  = busy && isFinal;

endmodule

// File: rtl/burst_col_sequencer_chk.sv
module burst_col_sequencer_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             colLast,
  input logic             errFlag
);

  logic       prevValid;
  logic       prevLast;
  logic [3:0] runCnt;
  logic       newBurst;
  logic [3:0] beatNum;

  assign newBurst = !prevValid || prevLast;
  assign beatNum  = newBurst ? 4'd1 : runCnt + 4'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevLast  <= 1'b0;
      runCnt    <= '0;
    end else begin
      prevValid <= colValid;
      prevLast  <= colLast;
      runCnt    <= colValid ? beatNum : 4'd0;
    end
  end

  // R7: final-beat marker only on a valid beat
  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  // R2: a burst runs on every cycle until its final beat
  a_r2_no_gap_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast) |=> colValid);

  // R5: bits above the widest window hold inside a burst
  a_r5_upper_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast) |=> (colOut[COL_W-1:3] == $past(colOut[COL_W-1:3])));

  // R10: error pulse never coincides with a beat
  a_r10_err_no_beat: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !colValid);

  // R2: bursts end after 2, 4 or 8 beats
  a_r2_burst_length: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> (beatNum == 4'd2 || beatNum == 4'd4 || beatNum == 4'd8));

  // R2: no burst exceeds eight beats
  a_r2_max_beats: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> (beatNum <= 4'd8));

endmodule

bind burst_col_sequencer burst_col_sequencer_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .colOut   (colOut),
  .colValid (colValid),
  .colLast  (colLast),
  .errFlag  (errFlag)
);

// File: tb/tb_burst_col_sequencer.sv
module tb_burst_col_sequencer;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startIn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b001;
  logic             interleave = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             colLast;
  logic             errFlag;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  burst_col_sequencer #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave),
    .colOut(colOut), .colValid(colValid), .colLast(colLast), .errFlag(errFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int expCol(input int col, input int len, input logic intl, input int i);
    int m = len - 1;
    int s = col & m;
    int off = intl ? ((s ^ i) & m) : ((s + i) & m);
    return (col & ~m) | off;
  endfunction

  // drive a start at the current negedge; returns at the negedge showing beat 0
  task automatic pulseStart(input int col, input logic [2:0] code, input logic intl);
    startCol = col[COL_W-1:0];
    lenCode = code;
    interleave = intl;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // checks n beats starting at the current negedge; leaves at negedge after last beat
  task automatic checkBeats(input string req, input int col, input logic [2:0] code,
                            input logic intl);
    int n = lenOf(code);
    for (int i = 0; i < n; i++) begin
      check(req, "valid", int'(colValid), 1);
      check(req, "col", int'(colOut), expCol(col, n, intl, i));
      check("R7", "last", int'(colLast), (i == n - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic runBurst(input string req, input int col, input logic [2:0] code,
                          input logic intl);
    pulseStart(col, code, intl);
    checkBeats(req, col, code, intl);
    check(req, "idle after burst", int'(colValid), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "valid", int'(colValid), 0);
    check("R1", "last", int'(colLast), 0);
    check("R1", "err", int'(errFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "valid after release", int'(colValid), 0);
  endtask

  task automatic testSequential();
    for (int s = 0; s < 8; s++) runBurst("R3", 10'h2A8 | s, 3'b011, 1'b0);
    runBurst("R3", 10'h101, 3'b010, 1'b0);
    runBurst("R3", 10'h103, 3'b010, 1'b0);
    runBurst("R3", 10'h001, 3'b001, 1'b0);
    runBurst("R2", 10'h000, 3'b001, 1'b0);
  endtask

  task automatic testInterleave();
    for (int s = 0; s < 8; s++) runBurst("R4", 10'h150 | s, 3'b011, 1'b1);
    runBurst("R4", 10'h205, 3'b010, 1'b1);
    runBurst("R4", 10'h207, 3'b010, 1'b1);
    runBurst("R4", 10'h3FF, 3'b001, 1'b1);
  endtask

  task automatic testUpperBits();
    // short bursts: bits 2 and 1 lie outside the window and must pass through
    runBurst("R5", 10'h3FE, 3'b001, 1'b0);
    runBurst("R5", 10'h1F6, 3'b010, 1'b1);
    runBurst("R5", 10'h1FA, 3'b001, 1'b1);
  endtask

  task automatic testMidChange();
    int n;
    pulseStart(10'h0C5, 3'b011, 1'b0);
    for (int i = 0; i < 8; i++) begin
      check("R6", "col", int'(colOut), expCol(10'h0C5, 8, 1'b0, i));
      startCol = 10'(i * 37 + 3);
      lenCode = 3'b001;
      interleave = 1'b1;
      @(negedge clk);
    end
    check("R6", "ended after 8", int'(colValid), 0);
    n = 0;
    n = n;
  endtask

  task automatic testBusyStart();
    pulseStart(10'h046, 3'b011, 1'b1);
    for (int i = 0; i < 8; i++) begin
      check("R9", "col", int'(colOut), expCol(10'h046, 8, 1'b1, i));
      if (i == 2 || i == 5) begin
        startCol = 10'h3C1;
        lenCode = 3'b001;
        interleave = 1'b0;
        startIn = 1'b1;
      end else startIn = 1'b0;
      @(negedge clk);
    end
    startIn = 1'b0;
    check("R9", "no extra burst", int'(colValid), 0);
  endtask

  task automatic testBackToBack();
    pulseStart(10'h013, 3'b010, 1'b0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R8", "at last", int'(colLast), 1);
    startCol = 10'h2E6;
    lenCode = 3'b011;
    interleave = 1'b1;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    checkBeats("R8", 10'h2E6, 3'b011, 1'b1);
    check("R8", "idle after", int'(colValid), 0);
  endtask

  task automatic testIllegal();
    logic [2:0] bad [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    foreach (bad[k]) begin
      pulseStart(10'h055, bad[k], 1'b0);
      check("R10", "err pulse", int'(errFlag), 1);
      check("R10", "no beat", int'(colValid), 0);
      @(negedge clk);
      check("R10", "err one cycle", int'(errFlag), 0);
      check("R10", "still no beat", int'(colValid), 0);
    end
    runBurst("R10", 10'h0A2, 3'b010, 1'b1);
  endtask

  initial begin
    testReset();
    testSequential();
    testInterleave();
    testUpperBits();
    testMidChange();
    testBusyStart();
    testBackToBack();
    testIllegal();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule